// File: doc/BRIEF.md
# Bounded Response Window Checker

A synthesizable run-time monitor for one request/acknowledge pair in a single clock domain. Every request opens its own response window, measured in clock edges after the edge that sampled the request. The window runs from offset LO to offset HI, and both ends count. The monitor raises a one-cycle violation pulse when a request is not answered the way the selected mode demands. It also shows a pending flag while any request is still waiting to be judged.

Three judging modes are supported. In the "some" mode, one high acknowledge anywhere in the window answers the request. In the "each" mode, the acknowledge must stay high on every edge of the window. In the "late" mode there is no upper bound: any acknowledge at offset LO or later answers the request. An end-of-test strobe then turns every request that is still open into a violation. Requests that overlap are tracked independently in a one-bit-per-offset age line. LO and HI are elaboration constants with 0 <= LO <= HI <= 16.

Timing convention: inputs are sampled at rising edges, and the request sampled at edge t has offset 0 at edge t. A verdict formed at edge k appears on `viol_o` during the cycle after edge k. `pending_o` is registered and shows the state after the most recent edge.

Top module: `rw_window_mon`

## Requirements
- R1: A synchronous active-high reset empties all tracking. During the cycle after a reset edge, `viol_o` and `pending_o` are 0. A request sampled on a reset edge is dropped.
- R2: Mode encoding: `mode_i` 0 selects "some", 1 selects "each", 2 selects "late", and 3 behaves as "some". In "some" mode, a request at edge t with no acknowledge on edges t+LO..t+HI gives a violation judged at edge t+HI.
- R3: In "some" mode both window bounds are inclusive. An acknowledge exactly at t+LO or at t+HI answers the request, while one at t+LO-1 or t+HI+1 does not. With LO equal to HI, only an acknowledge at exactly that offset answers it.
- R4: In "each" mode, a request at edge t is judged failing at the first edge in t+LO..t+HI where the acknowledge is low. It produces exactly one violation, and later low acknowledges for that request produce none.
- R5: In "late" mode, an acknowledge at any edge at or after t+LO answers the request, however late it comes. No violation is raised in this mode except on an end-of-test strobe.
- R6: In "late" mode, an end-of-test strobe at edge k raises a violation if any request not cleared earlier lacks an acknowledge at or after its own offset LO up to edge k. This includes a request sampled at edge k itself. The strobe then empties all tracking, with or without a violation.
- R7: In "some" and "each" modes the end-of-test strobe has no effect. Windows keep running and are judged as if it were low.
- R8: Overlapping requests are judged independently. Each has its own window, and a violation for one does not cancel another.
- R9: An acknowledge without an open request never causes a violation, and a cycle without a request never causes one by itself.
- R10: `pending_o` is high exactly when, after the latest edge, some request is still unjudged. In "some" mode that means unanswered and younger than HI. In "each" mode it means not failed and younger than HI. In "late" mode it means unanswered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request sampled each edge |
| ack_i | input | 1 | Acknowledge sampled each edge |
| mode_i | input | 2 | Judging mode: 0 some, 1 each, 2 late, 3 some |
| eot_i | input | 1 | End-of-test strobe, used in late mode |
| viol_o | output | 1 | One-cycle violation pulse |
| pending_o | output | 1 | Some request still awaits its verdict |

## Verification
Two situations can fall on the same edge: one request's verdict and another request's answer, or in late mode a fresh request and the end-of-test strobe. The bench provokes the first with back-to-back requests and a single acknowledge that answers the older request but is too early for the younger one. It provokes the second by raising request and strobe together. A scoreboard model that reasons over the recorded input history, request by request, judges both the violation pulse and the pending flag on every cycle. A second instance with LO equal to HI runs the same stimulus to cover the fixed-delay case.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;

  typedef enum logic [1:0] {
    CHK_SOME = 2'd0,
    CHK_EACH = 2'd1,
    CHK_LATE = 2'd2
  } rw_kind_e;

  // Map the mode pins to a judging kind; code 3 falls back to "some".
  function automatic rw_kind_e rw_decode(input logic [1:0] m);
    case (m)
      2'd1:    return CHK_EACH;
      2'd2:    return CHK_LATE;
      default: return CHK_SOME;
    endcase
  endfunction

  // An offset counts toward the window once it reaches the lower bound.
  function automatic bit rw_opens(input int age, input int lo);
    return age >= lo;
  endfunction

  // The window is judged for the last time at the upper bound.
  function automatic bit rw_closes(input int age, input int hi);
    return age == hi;
  endfunction

endpackage

// File: rtl/rw_slot.sv
`timescale 1ns/1ps
module rw_slot
  import rwin_pkg::*;
#(
  parameter int AGE = 0,
  parameter int LO  = 2,
  parameter int HI  = 5
) (
  input  logic     live_i,
  input  logic     ack_i,
  input  rw_kind_e kind_i,
  output logic     live_o,
  output logic     fail_o,
  output logic     spill_o
);

  localparam bit OPEN  = rw_opens(AGE, LO);
  localparam bit CLOSE = rw_closes(AGE, HI);

  logic answered;
  assign answered = OPEN && ack_i;

  always_comb begin
    live_o  = 1'b0;
    fail_o  = 1'b0;
    spill_o = 1'b0;
    case (kind_i)
      CHK_EACH: begin
        fail_o = live_i && OPEN && !ack_i;
        live_o = live_i && !CLOSE && !fail_o;
      end
      CHK_LATE: begin
        spill_o = live_i && CLOSE && !answered;
        live_o  = live_i && !CLOSE && !answered;
      end
      default: begin
        fail_o = live_i && CLOSE && !answered;
        live_o = live_i && !CLOSE && !answered;
      end
    endcase
  end

  always_comb begin
    AST_SLOT_SINGLE_FATE: assert (!(live_o && (fail_o || spill_o))); // R2
  end

endmodule

// File: rtl/rw_age_pipe.sv
`timescale 1ns/1ps
module rw_age_pipe
  import rwin_pkg::*;
#(
  parameter int LO = 2,
  parameter int HI = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          flush_i,
  input  logic          req_i,
  input  logic          ack_i,
  input  rw_kind_e      kind_i,
  output logic [HI:0]   held_o,
  output logic          fail_any_o,
  output logic          spill_o,
  output logic          live_any_o
);

  localparam int DEPTH = HI + 1;

  logic [DEPTH-1:0] held_q;
  logic [DEPTH-1:0] slot_in;
  logic [DEPTH-1:0] slot_live;
  logic [DEPTH-1:0] slot_fail;
  logic [DEPTH-1:0] slot_spill;

  // Offset 0 is the request on this edge; older offsets come from the line.
  always_comb begin
    slot_in[0] = req_i;
    for (int a = 1; a < DEPTH; a++) slot_in[a] = held_q[a-1];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rw_slot #(.AGE(g), .LO(LO), .HI(HI)) u_slot (
      .live_i (slot_in[g]),
      .ack_i  (ack_i),
      .kind_i (kind_i),
      .live_o (slot_live[g]),
      .fail_o (slot_fail[g]),
      .spill_o(slot_spill[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) held_q <= '0;
    else                  held_q <= slot_live;
  end

  assign held_o     = held_q;
  assign fail_any_o = |slot_fail;
  assign spill_o    = |slot_spill;
  assign live_any_o = |slot_live;

  AST_AGE_ZERO_FROM_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    held_q[0] |-> $past(req_i)); // R8

  for (genvar g = 1; g < DEPTH; g++) begin : g_step
    AST_AGE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      held_q[g] |-> $past(held_q[g-1])); // R8
  end

endmodule

// File: rtl/rw_late_tail.sv
`timescale 1ns/1ps
module rw_late_tail (
  input  logic clk_i,
  input  logic rst_i,
  input  logic flush_i,
  input  logic ack_i,
  input  logic spill_i,
  output logic tail_q_o,
  output logic tail_next_o
);

  logic tail_q;

  // Requests older than HI share one bit: any acknowledge answers all of them.
  assign tail_next_o = spill_i || (tail_q && !ack_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) tail_q <= 1'b0;
    else                  tail_q <= tail_next_o;
  end

  assign tail_q_o = tail_q;

  AST_TAIL_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (tail_q && ack_i && !spill_i) |=> !tail_q); // R5

endmodule

// File: rtl/rw_window_mon.sv
`timescale 1ns/1ps
module rw_window_mon
  import rwin_pkg::*;
#(
  parameter int LO = 2,
  parameter int HI = 5
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic [1:0] mode_i,
  input  logic       eot_i,
  output logic       viol_o,
  output logic       pending_o
);

  rw_kind_e    kind;
  logic        late;
  logic        flush;
  logic        fail_any;
  logic        spill;
  logic        live_any;
  logic [HI:0] held;
  logic        tail_q;
  logic        tail_next;
  logic        eot_fail;
  logic        viol_q;

  assign kind  = rw_decode(mode_i);
  assign late  = (kind == CHK_LATE);
  assign flush = late && eot_i;

  rw_age_pipe #(.LO(LO), .HI(HI)) u_pipe (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .flush_i   (flush),
    .req_i     (req_i),
    .ack_i     (ack_i),
    .kind_i    (kind),
    .held_o    (held),
    .fail_any_o(fail_any),
    .spill_o   (spill),
    .live_any_o(live_any)
  );

  rw_late_tail u_tail (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .flush_i    (flush),
    .ack_i      (ack_i),
    .spill_i    (spill),
    .tail_q_o   (tail_q),
    .tail_next_o(tail_next)
  );

  assign eot_fail = flush && (live_any || tail_next);

  always_ff @(posedge clk_i) begin
    if (rst_i) viol_q <= 1'b0;
    else       viol_q <= fail_any || eot_fail;
  end

  assign viol_o    = viol_q;
  assign pending_o = (|held) || tail_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pending_o && !req_i) |=> !viol_o); // R9

  AST_LATE_NO_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    (late && !eot_i) |=> !viol_o); // R5

  AST_EOT_INERT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!late && eot_i && !fail_any) |=> !viol_o); // R7

  AST_EOT_REPORTS: assert property (@(posedge clk_i) disable iff (rst_i)
    (late && eot_i && pending_o && !ack_i) |=> viol_o); // R6

  AST_EOT_EMPTIES: assert property (@(posedge clk_i) disable iff (rst_i)
    (late && eot_i) |=> !pending_o); // R6

endmodule

// File: tb/rw_window_mon_tb_top.sv
`timescale 1ns/1ps
module rw_window_mon_tb_top;

  localparam int LO_A = 2;
  localparam int HI_A = 5;
  localparam int LO_B = 4;
  localparam int HI_B = 4;
  localparam int NMAX = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       ack = 1'b0;
  logic       eot = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       viol_a, pend_a, viol_b, pend_b;

  always #2.5 clk = ~clk;

  rw_window_mon #(.LO(LO_A), .HI(HI_A)) dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req), .ack_i(ack),
    .mode_i(mode), .eot_i(eot), .viol_o(viol_a), .pending_o(pend_a));

  rw_window_mon #(.LO(LO_B), .HI(HI_B)) dut_fx (
    .clk_i(clk), .rst_i(rst), .req_i(req), .ack_i(ack),
    .mode_i(mode), .eot_i(eot), .viol_o(viol_b), .pending_o(pend_b));

  // Recorded input history, indexed by edge number (first edge is 1).
  bit rq[NMAX];
  bit ak[NMAX];
  bit eo[NMAX];
  bit rs[NMAX];
  int md[NMAX];

  int edges = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cur_mode = 0;
  bit done = 0;

  always @(posedge clk) edges <= edges + 1;

  typedef struct {
    int    idx;
    bit    va;
    bit    pa;
    bit    vb;
    bit    pb;
    string tag;
  } item_t;

  item_t sbq[$];

  function automatic bit any_ack(int a, int b);
    for (int c = a; c <= b; c++) if (c >= 0 && ak[c]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit all_ack(int a, int b);
    for (int c = a; c <= b; c++) if (c >= 0 && !ak[c]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int kind_of(int m);
    return (m == 1 || m == 2) ? m : 0;
  endfunction

  function automatic bit is_clr(int c);
    return rs[c] || (kind_of(md[c]) == 2 && eo[c]);
  endfunction

  function automatic bit survives(int t, int k);
    for (int c = t; c < k; c++) if (is_clr(c)) return 1'b0;
    return 1'b1;
  endfunction

  // Expected violation visible after edge k.
  function automatic bit exp_viol(int k, int lo, int hi);
    int m;
    m = kind_of(md[k]);
    if (rs[k]) return 1'b0;
    if (m == 2) begin
      if (!eo[k]) return 1'b0;
      for (int t = k; t >= 1; t--) begin
        if (t < k && is_clr(t)) break;
        if (rq[t] && !any_ack(t + lo, k)) return 1'b1;
      end
      return 1'b0;
    end
    for (int t = k - hi; t <= k - lo; t++) begin
      if (t < 1) continue;
      if (!rq[t] || !survives(t, k)) continue;
      if (m == 0 && t == k - hi && !any_ack(t + lo, k)) return 1'b1;
      if (m == 1 && all_ack(t + lo, k - 1) && !ak[k]) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Expected pending flag after edge k.
  function automatic bit exp_pend(int k, int lo, int hi);
    int m;
    m = kind_of(md[k]);
    if (rs[k] || (m == 2 && eo[k])) return 1'b0;
    for (int t = k; t >= 1; t--) begin
      if (is_clr(t)) break;
      if (!rq[t]) continue;
      if (m == 2) begin
        if (!any_ack(t + lo, k)) return 1'b1;
      end else if (k - t < hi) begin
        if (m == 0 ? !any_ack(t + lo, k) : all_ack(t + lo, k)) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // Driver: applies one edge of stimulus and queues the expected outcome.
  task automatic step(input bit r, input bit a, input bit e, input bit z, input string tag);
    item_t it;
    int k;
    @(posedge clk);
    #1;
    req  = r;
    ack  = a;
    eot  = e;
    rst  = z;
    mode = cur_mode[1:0];
    k = edges + 1;
    rq[k] = r; ak[k] = a; eo[k] = e; rs[k] = z; md[k] = cur_mode;
    it.idx = k;
    it.va  = exp_viol(k, LO_A, HI_A);
    it.pa  = exp_pend(k, LO_A, HI_A);
    it.vb  = exp_viol(k, LO_B, HI_B);
    it.pb  = exp_pend(k, LO_B, HI_B);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic seq(input bit [31:0] rv, input bit [31:0] av, input int n, input string tag);
    for (int i = 0; i < n; i++) step(rv[i], av[i], 1'b0, 1'b0, tag);
  endtask

  task automatic restart(input int m, input string tag);
    cur_mode = m;
    step(1'b0, 1'b0, 1'b0, 1'b1, tag);
    step(1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic chk(input bit got, input bit exp, input string what, input string tag, input int k);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s after edge %0d: actual %0b expected %0b", tag, what, k, got, exp);
    end
  endtask

  // Monitor: pops the item for the edge just passed and compares.
  always @(negedge clk) begin
    item_t it;
    if (!done && sbq.size() > 0 && sbq[0].idx == edges) begin
      it = sbq.pop_front();
      chk(viol_a, it.va, "viol (window 2..5)", it.tag, it.idx);
      chk(pend_a, it.pa, "pending (window 2..5)", it.tag, it.idx);
      chk(viol_b, it.vb, "viol (fixed 4)", it.tag, it.idx);
      chk(pend_b, it.pb, "pending (fixed 4)", it.tag, it.idx);
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state, request during reset dropped
    cur_mode = 0;
    step(0, 0, 0, 1, "R1");
    step(0, 0, 0, 1, "R1");
    step(1, 0, 0, 1, "R1");
    seq(32'h0, 32'h0, 8, "R1");

    // "some" mode: bound edges and fixed delay
    seq(32'h1, 32'h1 << 2, 8, "R3");
    seq(32'h1, 32'h1 << 5, 8, "R3");
    seq(32'h1, 32'h1 << 1, 9, "R3");
    seq(32'h1, 32'h1 << 6, 9, "R3");
    seq(32'h1, 32'h0, 8, "R2");
    seq(32'h1, 32'h1 << 4, 8, "R3");
    // overlap: one ack answers the older request, too early for the younger
    seq(32'h3, 32'h1 << 2, 10, "R8");
    seq(32'h5, 32'h0, 10, "R8");
    // ack without request, and silence
    seq(32'h0, 32'hFFFF, 16, "R9");
    seq(32'h0, 32'h0, 6, "R9");
    // strobe ignored outside late mode
    step(1, 0, 1, 0, "R7");
    seq(32'h0, 32'h0, 8, "R7");

    // "each" mode
    restart(1, "R1");
    seq(32'h1, 32'h3C, 8, "R4");
    seq(32'h1, 32'h34, 8, "R4");
    seq(32'h1, 32'h0, 8, "R4");
    seq(32'h1, 32'h10, 8, "R4");
    seq(32'h3, 32'h7C, 9, "R8");
    seq(32'h3, 32'h3C, 9, "R8");
    step(1, 1, 1, 0, "R7");
    seq(32'h0, 32'hFF, 8, "R7");
    seq(32'h0, 32'h0, 4, "R10");

    // "late" mode
    restart(2, "R1");
    seq(32'h1, 32'h0, 24, "R10");
    step(0, 1, 0, 0, "R5");
    seq(32'h0, 32'h0, 4, "R5");
    seq(32'h1, 32'h1 << 1, 4, "R6");
    step(0, 0, 1, 0, "R6");
    seq(32'h0, 32'h0, 3, "R6");
    step(1, 0, 1, 0, "R6");
    seq(32'h0, 32'h0, 3, "R6");
    step(0, 0, 1, 0, "R6");
    seq(32'h0, 32'h0, 2, "R6");
    seq(32'h3, 32'h0, 8, "R10");
    step(0, 1, 1, 0, "R6");
    seq(32'h0, 32'h0, 3, "R6");

    // code 3 acts as "some"
    restart(3, "R1");
    seq(32'h1, 32'h0, 8, "R2");
    seq(32'h1, 32'h1 << 3, 8, "R2");
    seq(32'h0, 32'h0, 3, "R2");

    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule